// File: doc/BRIEF.md
# Sparse Gradient Aggregator with Top-k Mutation Selection

This block merges sparse gradient reports from many workers into one dense sum per binary weight, then picks the weight flips to apply for the round. Workers stream (weight index, signed gradient) pairs in. A pair survives only if its gradient magnitude is strictly above a programmable threshold. Surviving gradients for the same index are added into a saturating 24-bit signed accumulator. The bank has `N_W` entries. A full 64-channel to 64-channel 3x3 layer needs 36864 entries, and the default is kept small.

When the end-of-round strobe arrives, input is held off and the block scans the bank. For each index it reads the current sign of the weight through a lookup port. An entry is dropped when the weight already sits at the value its gradient asks for. Of the entries that remain, it emits up to k indices in descending order of magnitude. The stream carries a valid/ready handshake and a last flag. After the last index has been taken, the whole bank is wiped in one cycle and a new round starts.

Selection runs one full scan of the bank per emitted index. The first scan also counts the eligible entries, so the last flag is known when each index is presented.

Top module: `agg_topk`

## Requirements
- R1: A pair is accumulated only when the absolute value of its 16-bit signed gradient is strictly greater than `thr`. A pair whose magnitude equals or is below `thr` has no effect on the round.
- R2: Accepted gradients that share an index, from any number of pairs, are summed into a single value for that index.
- R3: Each sum saturates at 24-bit signed limits: +8388607 and -8388608. Later additions start from the saturated value.
- R4: The lookup bit `wq_bit` is 1 for a weight of +1 and 0 for a weight of -1. A positive sum asks for +1 and is eligible only when the bit is 0. A negative sum asks for -1 and is eligible only when the bit is 1. A zero sum is never eligible.
- R5: Emitted indices come out in descending order of absolute sum. When two magnitudes are equal, the lower index comes first.
- R6: The number of indices emitted is the smaller of the eligible count and `k_in`, with `k_in` clamped to `K_MAX` (16). `out_last` is set on the final index. When nothing is emitted, no index is presented at all.
- R7: `in_ready` drops in the cycle after `round_end` is accepted. It stays low through selection and rises two cycles after the last index handshake. A pair held valid meanwhile is accepted into the next round.
- R8: After a round completes, every sum is zero, including entries that were not selected.
- R9: The first index is presented `N_W`+1 cycles after the clock edge that samples `round_end`. While `out_ready` is low, `out_idx` and `out_last` hold steady.
- R10: Under reset, `in_ready` is 1 and `out_valid` is 0.
- R11: A pair accepted in the same cycle as `round_end` counts toward the round that is ending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thr | input | 16 | Unsigned gradient magnitude threshold |
| in_valid | input | 1 | Pair present |
| in_ready | output | 1 | Pair accepted when high together with in_valid |
| in_idx | input | log2(N_W) | Weight index of the pair |
| in_grad | input | 16 | Signed gradient of the pair |
| round_end | input | 1 | End-of-round strobe, taken while in_ready is high |
| k_in | input | log2(K_MAX+1) | Requested number of mutations, sampled with round_end |
| wq_idx | output | log2(N_W) | Index whose current weight bit is requested |
| wq_bit | input | 1 | Current weight bit for wq_idx, returned in the same cycle |
| out_valid | output | 1 | Selected index present |
| out_ready | input | 1 | Consumer takes the index |
| out_idx | output | log2(N_W) | Selected weight index |
| out_last | output | 1 | Final index of the round |

## Verification
A pair changes its sum at the edge where it is handshaken. The first index is due exactly `N_W`+1 edges after `round_end` is sampled, and each later index arrives `N_W`+1 edges after the previous handshake. The bench counts edges from the `round_end` edge and requires the first `out_valid` on that exact count. It then samples outputs only at falling edges and compares each index at the handshake edge against a list it builds from its own saturating model and a selection sort. `in_ready` is checked low at the first emitted index, low again one cycle after the last handshake, and high on the cycle after that. Rounds with nothing to emit are watched for `N_W`+4 cycles so that any stray `out_valid` is seen.

// File: rtl/agg_pkg.sv
package agg_pkg;

    localparam int GRAD_W = 16;
    localparam int ACC_W  = 24;

    typedef logic signed [GRAD_W-1:0] grad_t;
    typedef logic signed [ACC_W-1:0]  acc_t;
    typedef logic        [ACC_W-1:0]  mag_t;

    typedef enum logic [2:0] {
        ST_ACCUM,
        ST_SCAN,
        ST_SDONE,
        ST_EMIT,
        ST_CLEAR
    } phase_e;

    typedef struct packed {
        logic elig;
        mag_t mag;
    } cand_t;

    // Saturating add of a gradient into a running sum.
    function automatic acc_t sat_add(acc_t a, grad_t g);
        logic signed [ACC_W:0] s;
        s = {a[ACC_W-1], a} + {{(ACC_W+1-GRAD_W){g[GRAD_W-1]}}, g};
        if (s[ACC_W] != s[ACC_W-1])
            sat_add = s[ACC_W] ? {1'b1, {(ACC_W-1){1'b0}}} : {1'b0, {(ACC_W-1){1'b1}}};
        else
            sat_add = s[ACC_W-1:0];
    endfunction

    // Magnitude of a sum; the most negative value maps to 2^(ACC_W-1).
    function automatic mag_t mag_of(acc_t a);
        acc_t n;
        n = -a;
        return a[ACC_W-1] ? mag_t'(n) : mag_t'(a);
    endfunction

    // Magnitude of a gradient, one bit wider than the gradient.
    function automatic logic [GRAD_W:0] grad_mag(grad_t g);
        logic [GRAD_W:0] x;
        x = {g[GRAD_W-1], g};
        return g[GRAD_W-1] ? (~x + 1'b1) : x;
    endfunction

endpackage

// File: rtl/grad_filter.sv
module grad_filter
    import agg_pkg::*;
(
    input  grad_t             grad_i,
    input  logic [GRAD_W-1:0] thr_i,
    output logic              pass_o
);

    always_comb begin
        pass_o = grad_mag(grad_i) > {1'b0, thr_i};
    end

endmodule

// File: rtl/acc_bank.sv
module acc_bank
    import agg_pkg::*;
#(
    parameter int N_W   = 64,
    parameter int IDX_W = $clog2(N_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  grad_t            wr_grad,
    input  logic             clr,
    input  logic             pick_en,
    input  logic [IDX_W-1:0] pick_idx,
    input  logic [IDX_W-1:0] rd_idx,
    output acc_t             rd_acc,
    output logic             rd_picked
);

    acc_t acc_q    [N_W];
    logic picked_q [N_W];

    generate
        for (genvar e = 0; e < N_W; e++) begin : g_ent
            always_ff @(posedge clk) begin
                if (rst || clr) begin
                    acc_q[e]    <= '0;
                    picked_q[e] <= 1'b0;
                end else begin
                    if (wr_en && (wr_idx == IDX_W'(e)))
                        acc_q[e] <= sat_add(acc_q[e], wr_grad);
                    if (pick_en && (pick_idx == IDX_W'(e)))
                        picked_q[e] <= 1'b1;
                end
            end
        end
    endgenerate

    always_comb begin
        rd_acc    = acc_q[rd_idx];
        rd_picked = picked_q[rd_idx];
    end

endmodule

// File: rtl/topk_scanner.sv
module topk_scanner
    import agg_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_best,
    input  logic             clr_cnt,
    input  logic             en,
    input  logic             count_en,
    input  logic [IDX_W-1:0] idx_i,
    input  acc_t             acc_i,
    input  logic             picked_i,
    input  logic             wbit_i,
    output logic             found_o,
    output logic [IDX_W-1:0] idx_o,
    output mag_t             mag_o,
    output logic [IDX_W:0]   cnt_o
);

    cand_t            cand;
    logic             take;
    logic             found_q;
    logic [IDX_W-1:0] idx_q;
    mag_t             mag_q;
    logic [IDX_W:0]   cnt_q;

    // Eligible when non-zero and the weight sign differs from the requested one:
    // a negative sum needs bit 1, a positive sum needs bit 0.
    always_comb begin
        cand.elig = (acc_i != '0) && (wbit_i == acc_i[ACC_W-1]);
        cand.mag  = mag_of(acc_i);
        take      = en && cand.elig && !picked_i && (!found_q || (cand.mag > mag_q));
    end

    always_ff @(posedge clk) begin
        if (rst || clr_best) begin
            found_q <= 1'b0;
            idx_q   <= '0;
            mag_q   <= '0;
        end else if (take) begin
            found_q <= 1'b1;
            idx_q   <= idx_i;
            mag_q   <= cand.mag;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr_cnt)
            cnt_q <= '0;
        else if (en && count_en && cand.elig)
            cnt_q <= cnt_q + 1'b1;
    end

    assign found_o = found_q;
    assign idx_o   = idx_q;
    assign mag_o   = mag_q;
    assign cnt_o   = cnt_q;

endmodule

// File: rtl/agg_topk.sv
module agg_topk
    import agg_pkg::*;
#(
    parameter int N_W   = 64,
    parameter int K_MAX = 16,
    localparam int IDX_W = $clog2(N_W),
    localparam int KW    = $clog2(K_MAX + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic        [GRAD_W-1:0] thr,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic        [IDX_W-1:0]  in_idx,
    input  logic signed [GRAD_W-1:0] in_grad,
    input  logic                     round_end,
    input  logic        [KW-1:0]     k_in,
    output logic        [IDX_W-1:0]  wq_idx,
    input  logic                     wq_bit,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic        [IDX_W-1:0]  out_idx,
    output logic                     out_last
);

    localparam int CNT_W = IDX_W + 1;
    localparam int LW    = (KW > CNT_W) ? KW : CNT_W;

    phase_e           st_q;
    logic [IDX_W-1:0] ptr_q;
    logic [LW-1:0]    k_q;
    logic [LW-1:0]    sent_q;
    logic             first_q;

    logic             pass;
    logic             wr_en;
    logic             start;
    logic             emit_fire;
    logic             last_flag;
    logic             clr_best;
    logic [LW-1:0]    k_eff;
    logic [LW-1:0]    n_out;
    logic [LW-1:0]    sent_nx;

    acc_t             rd_acc;
    logic             rd_picked;
    logic             best_found;
    logic [IDX_W-1:0] best_idx;
    mag_t             best_mag;
    logic [CNT_W-1:0] elig_cnt;

    grad_filter u_filter (
        .grad_i (in_grad),
        .thr_i  (thr),
        .pass_o (pass)
    );

    acc_bank #(.N_W(N_W), .IDX_W(IDX_W)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_idx    (in_idx),
        .wr_grad   (in_grad),
        .clr       (st_q == ST_CLEAR),
        .pick_en   (emit_fire),
        .pick_idx  (best_idx),
        .rd_idx    (ptr_q),
        .rd_acc    (rd_acc),
        .rd_picked (rd_picked)
    );

    topk_scanner #(.IDX_W(IDX_W)) u_scan (
        .clk      (clk),
        .rst      (rst),
        .clr_best (clr_best),
        .clr_cnt  (start),
        .en       (st_q == ST_SCAN),
        .count_en (first_q),
        .idx_i    (ptr_q),
        .acc_i    (rd_acc),
        .picked_i (rd_picked),
        .wbit_i   (wq_bit),
        .found_o  (best_found),
        .idx_o    (best_idx),
        .mag_o    (best_mag),
        .cnt_o    (elig_cnt)
    );

    always_comb begin
        in_ready  = (st_q == ST_ACCUM);
        wr_en     = in_valid && in_ready && pass;
        start     = in_ready && round_end;
        k_eff     = (LW'(k_in) > LW'(K_MAX)) ? LW'(K_MAX) : LW'(k_in);
        n_out     = (k_q < LW'(elig_cnt)) ? k_q : LW'(elig_cnt);
        sent_nx   = sent_q + 1'b1;
        last_flag = (sent_nx == n_out);
        emit_fire = (st_q == ST_EMIT) && out_ready;
        clr_best  = start || (emit_fire && !last_flag);
        out_valid = (st_q == ST_EMIT) && best_found;
        out_idx   = best_idx;
        out_last  = last_flag;
        wq_idx    = ptr_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_ACCUM;
            ptr_q   <= '0;
            k_q     <= '0;
            sent_q  <= '0;
            first_q <= 1'b0;
        end else begin
            case (st_q)
                ST_ACCUM: begin
                    if (round_end) begin
                        k_q     <= k_eff;
                        sent_q  <= '0;
                        first_q <= 1'b1;
                        ptr_q   <= '0;
                        st_q    <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    if (ptr_q == IDX_W'(N_W - 1)) begin
                        ptr_q <= '0;
                        st_q  <= ST_SDONE;
                    end else begin
                        ptr_q <= ptr_q + 1'b1;
                    end
                end
                ST_SDONE: begin
                    first_q <= 1'b0;
                    st_q    <= (sent_q < n_out) ? ST_EMIT : ST_CLEAR;
                end
                ST_EMIT: begin
                    if (out_ready) begin
                        sent_q <= sent_nx;
                        st_q   <= last_flag ? ST_CLEAR : ST_SCAN;
                    end
                end
                ST_CLEAR: st_q <= ST_ACCUM;
                default:  st_q <= ST_ACCUM;
            endcase
        end
    end

endmodule

// File: rtl/agg_topk_chk.sv
module agg_topk_chk
    import agg_pkg::*;
#(
    parameter int K_MAX = 16,
    parameter int IDX_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             in_ready,
    input logic             round_end,
    input logic             out_valid,
    input logic             out_ready,
    input logic [IDX_W-1:0] out_idx,
    input logic             out_last,
    input mag_t             sel_mag
);

    logic [7:0] hs_cnt;
    mag_t       prev_mag;
    logic       have_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_cnt    <= '0;
            prev_mag  <= '0;
            have_prev <= 1'b0;
        end else if (out_valid && out_ready) begin
            if (out_last) begin
                hs_cnt    <= '0;
                have_prev <= 1'b0;
            end else begin
                hs_cnt    <= hs_cnt + 1'b1;
                prev_mag  <= sel_mag;
                have_prev <= 1'b1;
            end
        end
    end

    p_reset_r10: assert property (@(posedge clk)
        rst |=> (in_ready && !out_valid));

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_idx) && $stable(out_last)));

    p_no_input_r7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    p_close_r7: assert property (@(posedge clk) disable iff (rst)
        (in_ready && round_end) |=> !in_ready);

    p_reopen_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_last) |=> !in_ready ##1 in_ready);

    p_order_r5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && have_prev) |-> (sel_mag <= prev_mag));

    p_k_limit_r6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (int'(hs_cnt) < K_MAX));

endmodule

bind agg_topk agg_topk_chk #(.K_MAX(K_MAX), .IDX_W(IDX_W)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .in_ready  (in_ready),
    .round_end (round_end),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_idx   (out_idx),
    .out_last  (out_last),
    .sel_mag   (best_mag)
);

// File: tb/test_agg_topk.sv
`timescale 1ns/1ps
module test_agg_topk;

    localparam int N  = 64;
    localparam int KM = 16;
    localparam int IW = 6;
    localparam int KW = 5;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic        [15:0]   thr = '0;
    logic                 in_valid = 1'b0;
    logic                 in_ready;
    logic        [IW-1:0] in_idx = '0;
    logic signed [15:0]   in_grad = '0;
    logic                 round_end = 1'b0;
    logic        [KW-1:0] k_in = '0;
    logic        [IW-1:0] wq_idx;
    logic                 wq_bit;
    logic                 out_valid;
    logic                 out_ready = 1'b0;
    logic        [IW-1:0] out_idx;
    logic                 out_last;

    int          macc [N];
    bit          wbit [N];
    int          exp_list [KM];
    int          exp_n;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          stall_en = 1'b0;
    logic [31:0] rng = 32'h1234_5678;

    always #2.5 clk = ~clk;

    assign wq_bit = wbit[wq_idx];

    agg_topk i_agg_topk (
        .clk       (clk),
        .rst       (rst),
        .thr       (thr),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_idx    (in_idx),
        .in_grad   (in_grad),
        .round_end (round_end),
        .k_in      (k_in),
        .wq_idx    (wq_idx),
        .wq_bit    (wq_bit),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_idx   (out_idx),
        .out_last  (out_last)
    );

    function automatic logic [31:0] rnd();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
        return rng;
    endfunction

    function automatic int absv(int v);
        return (v < 0) ? -v : v;
    endfunction

    task automatic check(bit ok, string req, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // R1 filter, R2 summing, R3 saturation in the reference model
    task automatic model_add(int idx, int g);
        if (absv(g) > int'(thr)) begin
            int t;
            t = macc[idx] + g;
            if (t > 8388607)  t = 8388607;
            if (t < -8388608) t = -8388608;
            macc[idx] = t;
        end
    endtask

    // R4 eligibility, R5 ordering, R6 count in the reference selection
    task automatic compute_expected(int k);
        bit used [N];
        int kk;
        kk = (k > KM) ? KM : k;
        exp_n = 0;
        for (int j = 0; j < kk; j++) begin
            int best;
            best = -1;
            for (int i = 0; i < N; i++) begin
                if (macc[i] != 0 && !used[i] && (wbit[i] == (macc[i] < 0))) begin
                    if (best < 0 || absv(macc[i]) > absv(macc[best])) best = i;
                end
            end
            if (best < 0) break;
            used[best] = 1'b1;
            exp_list[exp_n] = best;
            exp_n++;
        end
    endtask

    task automatic send_pair(int idx, int g);
        int guard;
        @(negedge clk);
        in_valid = 1'b1;
        in_idx   = idx[IW-1:0];
        in_grad  = g[15:0];
        guard = 0;
        while (!in_ready && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        @(posedge clk);
        model_add(idx, g);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run_round(string tag, int k, bit co, int cidx, int cg,
                             bit pend, int pidx, int pg);
        int  lat;
        int  j;
        int  guard;
        bit  seen_v;
        @(negedge clk);
        round_end = 1'b1;
        k_in      = k[KW-1:0];
        if (co) begin
            in_valid = 1'b1;
            in_idx   = cidx[IW-1:0];
            in_grad  = cg[15:0];
        end
        @(posedge clk);
        if (co) model_add(cidx, cg);
        @(negedge clk);
        round_end = 1'b0;
        in_valid  = 1'b0;
        if (pend) begin
            in_valid = 1'b1;
            in_idx   = pidx[IW-1:0];
            in_grad  = pg[15:0];
        end
        compute_expected(k);
        if (exp_n > 0) begin
            lat = 0;
            while (!out_valid && lat < N + 40) begin
                @(posedge clk);
                lat++;
                @(negedge clk);
            end
            check(lat == N + 1, {tag, " R9 first index latency"}, lat, N + 1);
            check(in_ready == 1'b0, {tag, " R7 input held off in selection"}, in_ready, 0);
            j = 0;
            guard = 0;
            while (j < exp_n && guard < 20000) begin
                if (out_valid) begin
                    out_ready = !(stall_en && (rnd() % 3 == 0));
                    if (out_ready) begin
                        check(int'(out_idx) == exp_list[j], {tag, " R5 index"}, out_idx, exp_list[j]);
                        check(out_last == (j == exp_n - 1), {tag, " R6 last flag"}, out_last, (j == exp_n - 1));
                        j++;
                    end
                end
                @(posedge clk);
                @(negedge clk);
                out_ready = 1'b0;
                guard++;
            end
            check(j == exp_n, {tag, " R6 index count"}, j, exp_n);
            check(in_ready == 1'b0, {tag, " R7 closed during clear"}, in_ready, 0);
            @(negedge clk);
            check(in_ready == 1'b1, {tag, " R7 reopened after clear"}, in_ready, 1);
        end else begin
            seen_v = 1'b0;
            repeat (N + 4) begin
                @(negedge clk);
                if (out_valid) seen_v = 1'b1;
            end
            check(!seen_v, {tag, " R6 nothing emitted"}, seen_v, 0);
            check(in_ready == 1'b1, {tag, " R7 reopened"}, in_ready, 1);
        end
        for (int i = 0; i < N; i++) macc[i] = 0;
        if (pend) begin
            guard = 0;
            while (!in_ready && guard < 5000) begin
                @(negedge clk);
                guard++;
            end
            @(posedge clk);
            model_add(pidx, pg);
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int ks [8];
        ks = '{1, 3, 16, 7, 0, 16, 31, 5};
        for (int i = 0; i < N; i++) begin
            macc[i] = 0;
            wbit[i] = 1'b0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        check(in_ready == 1'b1, "R10 in_ready under reset", in_ready, 1);
        check(out_valid == 1'b0, "R10 out_valid under reset", out_valid, 0);
        rst = 1'b0;

        // R1: threshold boundary (equal magnitude is dropped)
        thr = 16'd100;
        wbit[40] = 1'b0; wbit[41] = 1'b0; wbit[42] = 1'b1; wbit[43] = 1'b1;
        send_pair(40, 100);
        send_pair(41, 101);
        send_pair(42, -100);
        send_pair(43, -101);
        run_round("R1", 16, 1'b0, 0, 0, 1'b0, 0, 0);

        // R2: sums across several pairs per index
        thr = 16'd0;
        send_pair(7, 300);
        send_pair(7, 300);
        send_pair(8, 500);
        send_pair(9, 700);
        send_pair(9, -400);
        run_round("R2", 16, 1'b0, 0, 0, 1'b0, 0, 0);

        // R4 masking and R5 tie order
        wbit[20] = 1'b1; wbit[30] = 1'b1; wbit[31] = 1'b0;
        send_pair(3, 500);
        send_pair(10, 500);
        send_pair(20, -500);
        send_pair(30, 900);
        send_pair(31, -800);
        run_round("R4", 16, 1'b0, 0, 0, 1'b0, 0, 0);

        // R3: saturation at both limits
        wbit[12] = 1'b1; wbit[13] = 1'b1;
        repeat (300) send_pair(5, 32767);
        repeat (256) send_pair(6, 32767);
        send_pair(5, -32767);
        repeat (300) send_pair(12, -32768);
        repeat (256) send_pair(13, -32767);
        send_pair(12, 32767);
        run_round("R3", 16, 1'b0, 0, 0, 1'b0, 0, 0);

        // R11: pair arriving with the end-of-round strobe
        send_pair(50, 1000);
        run_round("R11", 16, 1'b1, 51, 2000, 1'b0, 0, 0);

        // R7: pair held during selection lands in the next round
        send_pair(2, 900);
        send_pair(4, 800);
        run_round("R7", 1, 1'b0, 0, 0, 1'b1, 60, 1234);

        // R8: leftovers cleared; only the held pair remains
        run_round("R8", 16, 1'b0, 0, 0, 1'b0, 0, 0);

        // R6: k of zero, and k above the limit clamped to 16
        send_pair(1, 50);
        run_round("R6", 0, 1'b0, 0, 0, 1'b0, 0, 0);
        for (int i = 0; i < 20; i++) send_pair(i + 21, 100 * (i + 1));
        run_round("R6", 31, 1'b0, 0, 0, 1'b0, 0, 0);

        // Sweep of mixed rounds with output stalls
        stall_en = 1'b1;
        for (int r = 0; r < 8; r++) begin
            thr = 16'(rnd() % 3000);
            for (int i = 0; i < N; i++) wbit[i] = rnd() % 2;
            for (int p = 0; p < 40; p++) begin
                int idx;
                int g;
                idx = int'(rnd() % ((r % 2 == 1) ? 16 : 64));
                g   = int'($signed(16'(rnd())));
                send_pair(idx, g);
            end
            run_round("R5", ks[r], 1'b0, 0, 0, 1'b0, 0, 0);
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule